// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a processor whose instructions are all 32 bits wide and word aligned. In each cycle it takes the decoded control class of the instruction at the current address together with its displacement field, its jump-target field, two register operands and a register value. From these it forms the address of the next instruction. When the instruction resolves, signalled by a step strobe, the new address is loaded into the program counter.

The unit supports five kinds of redirection besides plain sequential flow. Two are conditional branches: one taken on equal operands and one on unequal operands. Their targets are relative to the incremented address, with the displacement counted in words. The other three are a region jump, a region jump that also links, and a jump to a register. A region jump keeps the top bits of the incremented address and fills the rest from the instruction's target field. For the linking jump the unit also raises a write enable and presents the return address, which the register file stores in register 31.

Top module: `pc_steer`

## Requirements
- R1: While reset is applied, and until the first cycle with `step` high after reset, `pc` equals the parameter `RESET_VEC` (default 0x0040_0000) and `link_we` is 0.
- R2: For class code 0 (sequential), and for the unused codes 6 and 7, `pc_next` equals `pc`+4 modulo 2^32.
- R3: For class code 1 (branch-if-equal), `pc_next` is `pc`+4 plus the 16-bit `disp` sign-extended and multiplied by four when `op_a` equals `op_b`. Otherwise `pc_next` is `pc`+4.
- R4: For class code 2 (branch-if-unequal), the branch target is taken when `op_a` differs from `op_b`. When the operands are equal, `pc_next` is `pc`+4.
- R5: For class code 3 (region jump), `pc_next` is {bits 31..28 of `pc`+4, `jtarget`[25:0], 2'b00}.
- R6: For class code 4 (linking jump), `pc_next` is formed as in R5. In a cycle with `step` high, `link_we` is 1 and `link_val` equals `pc`+4.
- R7: For class code 5 (register jump), `pc_next` equals `jreg` in full, with no alignment applied.
- R8: `link_we` is 0 for every class other than 4, and it is 0 in any cycle where `step` is low.
- R9: On a rising clock edge with `step` high, `pc` takes the value `pc_next` had before the edge. With `step` low, `pc` holds its value.
- R10: The region bits of a jump come from `pc`+4 and not from `pc`. A jump at 0x0FFF_FFFC therefore lands in region 0x1, and a backward branch with `disp` 0x8000 moves the target down by 0x20000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | Instruction resolves this cycle; loads the PC |
| ctl_class | input | 3 | Control class: 0 seq, 1 branch-equal, 2 branch-unequal, 3 jump, 4 jump-link, 5 register jump |
| disp | input | 16 | Branch displacement in words, signed |
| jtarget | input | 26 | Jump target word index within the region |
| op_a | input | 32 | First compare operand |
| op_b | input | 32 | Second compare operand |
| jreg | input | 32 | Register value for the register jump |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write enable for the return address into register 31 |
| link_val | output | 32 | Return address (PC + 4) |

## Verification
Several properties are checked by assertions in every cycle. The PC holds when not stepped and loads `pc_next` when stepped. The link enable appears only for a stepped linking jump and then carries PC+4. A not-taken equal branch falls through, a register jump passes `jreg` unchanged, and both jump kinds keep the region bits of PC+4. The exact arithmetic of branch targets needs the bench's scenarios: negative displacements, address wrap at the top of memory, and region crossings at 0x0FFF_FFFC. The same holds for the reset vector and for the treatment of the unused class codes. The bench's reference model recomputes each of these every cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    CL_SEQ = 3'd0,
    CL_BEQ = 3'd1,
    CL_BNE = 3'd2,
    CL_JMP = 3'd3,
    CL_JAL = 3'd4,
    CL_JR  = 3'd5
  } pc_class_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_target.sv
// Forms the sequential address, the word-scaled branch target and the
// region jump target, all based on the incremented address.
module pcs_target #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned JT_W   = 26
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [DISP_W-1:0] disp,
  input  logic [JT_W-1:0]   jtarget,
  output logic [XLEN-1:0]   pc_inc,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   jmp_tgt
);
  import pcs_pkg::*;
  localparam int unsigned SH_W = 2;
  localparam int unsigned SX_W = XLEN - DISP_W - SH_W;
  localparam int unsigned UP_W = XLEN - JT_W - SH_W;

  logic [XLEN-1:0] disp_ext;

  always_comb begin
    pc_inc   = pc_cur + XLEN'(INSN_BYTES);
    disp_ext = {{SX_W{disp[DISP_W-1]}}, disp, {SH_W{1'b0}}};
    br_tgt   = pc_inc + disp_ext;
  end

  generate
    if (UP_W > 0) begin : g_region
      assign jmp_tgt = {pc_inc[XLEN-1 -: UP_W], jtarget, {SH_W{1'b0}}};
    end else begin : g_flat
      assign jmp_tgt = {jtarget[XLEN-SH_W-1:0], {SH_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/pcs_cond.sv
// Equality compare and branch decision.
module pcs_cond #(
  parameter int unsigned XLEN = 32
) (
  input  pcs_pkg::pc_class_e cls,
  input  logic [XLEN-1:0]    op_a,
  input  logic [XLEN-1:0]    op_b,
  output logic               taken
);
  import pcs_pkg::*;
  logic same;

  always_comb begin
    same = (op_a == op_b);
    unique case (cls)
      CL_BEQ:  taken = same;
      CL_BNE:  taken = !same;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcs_select.sv
// Chooses the next address among the candidates and flags the linking jump.
module pcs_select #(
  parameter int unsigned XLEN = 32
) (
  input  pcs_pkg::pc_class_e cls,
  input  logic               taken,
  input  logic [XLEN-1:0]    pc_inc,
  input  logic [XLEN-1:0]    br_tgt,
  input  logic [XLEN-1:0]    jmp_tgt,
  input  logic [XLEN-1:0]    jreg,
  output logic [XLEN-1:0]    nxt,
  output logic               is_link
);
  import pcs_pkg::*;

  always_comb begin
    nxt     = pc_inc;
    is_link = 1'b0;
    case (cls)
      CL_BEQ, CL_BNE: nxt = taken ? br_tgt : pc_inc;
      CL_JMP:         nxt = jmp_tgt;
      CL_JAL: begin
        nxt     = jmp_tgt;
        is_link = 1'b1;
      end
      CL_JR:          nxt = jreg;
      default:        nxt = pc_inc;
    endcase
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned DISP_W    = 16,
  parameter int unsigned JT_W      = 26,
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        ctl_class,
  input  logic [DISP_W-1:0] disp,
  input  logic [JT_W-1:0]   jtarget,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [XLEN-1:0]   jreg,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_next,
  output logic              link_we,
  output logic [XLEN-1:0]   link_val
);
  import pcs_pkg::*;
  localparam int unsigned UP_W = XLEN - JT_W - 2;

  logic              rst_q_n;
  pc_class_e         cls;
  logic              taken;
  logic              is_link;
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [XLEN-1:0]   pc_inc, br_tgt, jmp_tgt, nxt;

  assign cls = pc_class_e'(ctl_class);

  pcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  pcs_target #(.XLEN(XLEN), .DISP_W(DISP_W), .JT_W(JT_W)) u_tgt (
    .pc_cur(pc_q), .disp(disp), .jtarget(jtarget),
    .pc_inc(pc_inc), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
  );

  pcs_cond #(.XLEN(XLEN)) u_cond (
    .cls(cls), .op_a(op_a), .op_b(op_b), .taken(taken)
  );

  pcs_select #(.XLEN(XLEN)) u_sel (
    .cls(cls), .taken(taken), .pc_inc(pc_inc), .br_tgt(br_tgt),
    .jmp_tgt(jmp_tgt), .jreg(jreg), .nxt(nxt), .is_link(is_link)
  );

  // next-state
  always_comb begin
    pc_d = pc_q;
    if (step) pc_d = nxt;
  end

  // register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pc_q <= XLEN'(RESET_VEC);
    else          pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign pc_next  = nxt;
  assign link_we  = step & is_link & rst_q_n;
  assign link_val = pc_inc;

  // R9: stepped load and hold
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    step |=> (pc == $past(pc_next)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step |=> $stable(pc));
  // R6: link enable only for stepped linking jump, with PC+4
  p_link_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    link_we |-> (ctl_class == 3'd4 && step && link_val == pc + XLEN'(4)));
  // R8: no link otherwise
  p_nolink_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_class != 3'd4 || !step) |-> !link_we);
  // R3: equal-branch with unequal operands falls through
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_class == 3'd1 && op_a != op_b) |-> (pc_next == pc + XLEN'(4)));
  // R7: register jump passes the register through
  p_jr_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_class == 3'd5) |-> (pc_next == jreg));
  // R10: region bits of both jumps come from PC+4
  p_region_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_class == 3'd3 || ctl_class == 3'd4) |->
      (pc_next[XLEN-1 -: UP_W] == link_val[XLEN-1 -: UP_W]));
endmodule

// File: tb/sim_pc_steer.sv
`timescale 1ns/1ps
module sim_pc_steer;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step;
  logic [2:0]  ctl_class;
  logic [15:0] disp;
  logic [25:0] jtarget;
  logic [31:0] op_a, op_b, jreg;
  logic [31:0] pc, pc_next, link_val;
  logic        link_we;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc;
  bit done = 0;

  always #10 clk = ~clk;

  pc_steer #(.RESET_VEC(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .ctl_class(ctl_class),
    .disp(disp), .jtarget(jtarget), .op_a(op_a), .op_b(op_b), .jreg(jreg),
    .pc(pc), .pc_next(pc_next), .link_we(link_we), .link_val(link_val)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(input logic [2:0] c, input logic [31:0] p,
      input logic [15:0] d, input logic [25:0] t, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] r);
    longint seqa, off;
    seqa = longint'(p) + 4;
    off  = longint'($signed(d)) * 4;
    case (c)
      3'd1: return (a == b) ? 32'(seqa + off) : 32'(seqa);
      3'd2: return (a != b) ? 32'(seqa + off) : 32'(seqa);
      3'd3, 3'd4: return (32'(seqa) & 32'hF000_0000) | (32'(t) * 4);
      3'd5: return r;
      default: return 32'(seqa);
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic apply(input logic [2:0] c, input logic [15:0] d,
      input logic [25:0] t, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic st, input string tag);
    logic [31:0] en;
    ctl_class = c; disp = d; jtarget = t; op_a = a; op_b = b; jreg = r; step = st;
    #1;
    en = ref_next(c, model_pc, d, t, a, b, r);
    check("R9", "pc", pc, model_pc);
    check(tag, "pc_next", pc_next, en);
    check((c == 3'd4) ? "R6" : "R8", "link_we", {31'd0, link_we}, {31'd0, st && c == 3'd4});
    if (st && c == 3'd4) check("R6", "link_val", link_val, model_pc + 32'd4);
    @(posedge clk);
    if (st) model_pc = en;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; ctl_class = 3'd0; disp = '0; jtarget = '0;
    op_a = '0; op_b = '0; jreg = '0;
    model_pc = RV;
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc, RV);
    check("R1", "link_we in reset", {31'd0, link_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "pc after release", pc, RV);

    // R2 sequential, unused codes
    apply(3'd0, 16'h0, 26'h0, 0, 0, 0, 1'b1, "R2");
    apply(3'd6, 16'hFFFF, 26'h3, 1, 1, 9, 1'b1, "R2");
    apply(3'd7, 16'h1234, 26'h3, 1, 2, 9, 1'b1, "R2");
    // R3 equal branch taken and not taken
    apply(3'd1, 16'h0010, 26'h0, 32'h55, 32'h55, 0, 1'b1, "R3");
    apply(3'd1, 16'h0010, 26'h0, 32'h55, 32'h56, 0, 1'b1, "R3");
    // R4 unequal branch taken and not taken
    apply(3'd2, 16'hFFFE, 26'h0, 32'h1, 32'h2, 0, 1'b1, "R4");
    apply(3'd2, 16'hFFFE, 26'h0, 32'h7, 32'h7, 0, 1'b1, "R4");
    // R10 large backward branch
    apply(3'd1, 16'h8000, 26'h0, 32'h9, 32'h9, 0, 1'b1, "R10");
    // R5 / R6 jumps
    apply(3'd3, 16'h0, 26'h123_4567, 0, 0, 0, 1'b1, "R5");
    apply(3'd4, 16'h0, 26'h000_0040, 0, 0, 0, 1'b1, "R6");
    // R7 register jump, unaligned
    apply(3'd5, 16'h0, 26'h0, 0, 0, 32'hDEAD_BEEF, 1'b1, "R7");
    // R10 region crossing
    apply(3'd5, 16'h0, 26'h0, 0, 0, 32'h0FFF_FFFC, 1'b1, "R7");
    apply(3'd3, 16'h0, 26'h000_0010, 0, 0, 0, 1'b1, "R10");
    check("R10", "region", model_pc, 32'h1000_0040);
    apply(3'd5, 16'h0, 26'h0, 0, 0, 32'h0FFF_FFF8, 1'b1, "R7");
    apply(3'd4, 16'h0, 26'h000_0010, 0, 0, 0, 1'b1, "R10");
    check("R10", "same region", model_pc, 32'h0000_0040);
    // R2 wrap at top
    apply(3'd5, 16'h0, 26'h0, 0, 0, 32'hFFFF_FFFC, 1'b1, "R7");
    apply(3'd0, 16'h0, 26'h0, 0, 0, 0, 1'b1, "R2");
    check("R2", "wrap", model_pc, 32'h0);
    // R8/R9 stalled linking jump: no link, pc holds
    apply(3'd4, 16'h0, 26'h3FF_FFFF, 0, 0, 0, 1'b0, "R8");
    apply(3'd1, 16'h0004, 26'h0, 3, 3, 0, 1'b0, "R9");
    check("R9", "hold", pc, 32'h0);

    for (int i = 0; i < 300; i++) begin
      logic [2:0]  c;
      logic [31:0] a, b;
      c = 3'($urandom % 8);
      a = $urandom % 4;
      b = $urandom % 4;
      apply(c, 16'($urandom), 26'($urandom), a, b, $urandom & 32'hFFFF_FFFC,
            1'($urandom % 4 != 0), tag_of(c));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule